// File: doc/BRIEF.md
# NV12 Line Request Sequencer

This block drives a memory writer or reader that transfers one 4:2:0 semi-planar (NV12) frame. A single start pulse captures the frame geometry: a base address, the pixel width W, the line count H, and a separate stride for each plane. The block then issues one request per memory line. Each request carries a start address and a byte count, and passes through a valid/ready handshake to the downstream burst engine. The block does not move any data itself.

The luma plane is one byte per pixel and begins at the base address. The block requests its H lines first, with consecutive lines one luma stride apart. The chroma plane holds one interleaved U/V byte pair for every 2×2 block of luma pixels, so each chroma line is also W bytes long. It begins W·H bytes after the base. The block requests its H/2 lines, one chroma stride apart, straight after the last luma line. Chroma line k therefore serves luma rows 2k and 2k+1. Padding bytes between the line length and the stride are never requested.

A controller state machine steps through four states. IDLE waits for start. A start with a valid geometry moves IDLE→LUMA. If the geometry is invalid the block stays in IDLE and flags the error. LUMA→CHROMA happens on acceptance of the last luma line. CHROMA→FIN happens on acceptance of the last chroma line. FIN→IDLE always takes exactly one cycle, during which `done` is high.

Top module: `nv12_line_seq`

## Requirements
- R1: After reset, `req_valid`, `done`, `busy` and `config_error` are all 0.
- R2: A start in IDLE with a valid geometry presents the first request in the next cycle, with `req_addr` = base, `req_len` = W and `req_chroma` = 0.
- R3: Luma request k (k = 0..H-1) has `req_addr` = base + k·luma_stride, `req_len` = W and `req_chroma` = 0.
- R4: Chroma request k (k = 0..H/2-1) has `req_addr` = base + W·H + k·chroma_stride, `req_len` = W and `req_chroma` = 1. The first chroma request is presented in the cycle after the last luma request is accepted.
- R5: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_addr`, `req_len` and `req_chroma` hold their values. The line sequence advances only on a cycle with both signals high.
- R6: `done` is 1 for exactly one cycle: the cycle after the last chroma request is accepted. `req_valid` is 0 in that cycle, and `busy` is 0 in the cycle after it.
- R7: A start in IDLE where W or H is odd or zero, or where either stride is smaller than W, issues no request and leaves `busy` at 0. In that case `config_error` reads 1 from the next cycle until the next start. A start with a valid geometry clears it.
- R8: `start` has no effect while a frame is in progress (`busy` = 1).
- R9: The geometry inputs are captured at the accepted start. Changing them during a frame does not alter any request of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a frame (honoured only in IDLE) |
| base_addr | input | AW | Byte address of the first luma pixel |
| width | input | DW | Pixels per line W (bytes per line in both planes) |
| height | input | DW | Luma lines H |
| luma_stride | input | SW | Bytes between consecutive luma line starts |
| chroma_stride | input | SW | Bytes between consecutive chroma line starts |
| req_valid | output | 1 | A line request is presented |
| req_ready | input | 1 | Downstream accepts the presented request |
| req_addr | output | AW | Start byte address of the requested line |
| req_len | output | DW | Byte count of the requested line |
| req_chroma | output | 1 | 1 when the request belongs to the chroma plane |
| busy | output | 1 | A frame is in progress (any state but IDLE) |
| done | output | 1 | One-cycle pulse after the final chroma line is accepted |
| config_error | output | 1 | Last start was refused for an invalid geometry |

## Verification
Several properties are checked on every cycle. While a request stalls, it must hold steady. Each accepted luma line that is not the last must move the address by the luma stride. The first chroma request must land on base plus W·H. `done` must follow acceptance of the final chroma line and never last two cycles. A raised error flag must never coexist with a request. The bench scenarios cover the things a per-cycle property cannot. They confirm the complete request count per plane and the exact address of every line under random backpressure. They show that start pulses and input changes injected mid-frame leave the sequence untouched. They also run the minimal 2×2 frame, strides equal to the width, and each refusal cause.

// File: rtl/nv12_seq_pkg.sv
package nv12_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LUMA   = 2'd1,
        ST_CHROMA = 2'd2,
        ST_FIN    = 2'd3
    } seq_state_e;

    typedef enum logic {
        PLANE_LUMA   = 1'b0,
        PLANE_CHROMA = 1'b1
    } plane_e;

endpackage

// File: rtl/nv12_cfg_check.sv
module nv12_cfg_check #(
    parameter int DW = 12,
    parameter int SW = 16
) (
    input  logic [DW-1:0] width,
    input  logic [DW-1:0] height,
    input  logic [SW-1:0] luma_stride,
    input  logic [SW-1:0] chroma_stride,
    output logic          cfg_bad
);
    localparam int CW = (DW > SW) ? DW : SW;

    logic [CW-1:0] w_ext;
    logic [CW-1:0] ls_ext;
    logic [CW-1:0] cs_ext;
    logic          odd_dim;
    logic          zero_dim;
    logic          short_stride;

    always_comb begin
        w_ext        = CW'(width);
        ls_ext       = CW'(luma_stride);
        cs_ext       = CW'(chroma_stride);
        odd_dim      = width[0] | height[0];
        zero_dim     = (width == '0) | (height == '0);
        short_stride = (ls_ext < w_ext) | (cs_ext < w_ext);
        cfg_bad      = odd_dim | zero_dim | short_stride;
    end

endmodule

// File: rtl/nv12_plane_walker.sv
module nv12_plane_walker #(
    parameter int AW = 32,
    parameter int CW = 12,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [CW-1:0] load_lines,
    input  logic [SW-1:0] stride,
    input  logic          step,
    output logic [AW-1:0] line_addr,
    output logic          last_line
);
    logic [AW-1:0] addr_q;
    logic [CW-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q   <= '0;
            remain_q <= '0;
        end else if (load) begin
            addr_q   <= load_addr;
            remain_q <= load_lines;
        end else if (step) begin
            addr_q   <= addr_q + AW'(stride);
            remain_q <= remain_q - 1'b1;
        end
    end

    always_comb begin
        line_addr = addr_q;
        last_line = (remain_q == CW'(1));
    end

    // R5: the line count never underflows while stepping
    a_r5_no_step_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |-> (remain_q != '0));

endmodule

// File: rtl/nv12_line_seq.sv
module nv12_line_seq
    import nv12_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 12,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [DW-1:0] width,
    input  logic [DW-1:0] height,
    input  logic [SW-1:0] luma_stride,
    input  logic [SW-1:0] chroma_stride,
    output logic          req_valid,
    input  logic          req_ready,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_len,
    output logic          req_chroma,
    output logic          busy,
    output logic          done,
    output logic          config_error
);
    localparam int PW = 2 * DW;

    seq_state_e    state_q;
    seq_state_e    state_d;
    logic [DW-1:0] len_q;
    logic [DW-1:0] height_q;
    logic [AW-1:0] base_q;
    logic [SW-1:0] luma_stride_q;
    logic [SW-1:0] chroma_stride_q;
    logic          cfg_err_q;

    logic          cfg_bad;
    logic          idle;
    logic          start_take;
    logic          accept;
    logic [PW-1:0] luma_bytes;
    logic [AW-1:0] chroma_base;
    logic [DW-1:0] chroma_lines;
    logic [AW-1:0] luma_addr;
    logic [AW-1:0] chroma_addr;
    logic          luma_last;
    logic          chroma_last;
    logic          luma_step;
    logic          chroma_step;

    nv12_cfg_check #(.DW(DW), .SW(SW)) u_cfg (
        .width         (width),
        .height        (height),
        .luma_stride   (luma_stride),
        .chroma_stride (chroma_stride),
        .cfg_bad       (cfg_bad)
    );

    always_comb begin
        idle         = (state_q == ST_IDLE);
        start_take   = idle && start && !cfg_bad;
        luma_bytes   = PW'(width) * PW'(height);
        chroma_base  = base_addr + AW'(luma_bytes);
        chroma_lines = height >> 1;
        accept       = req_valid && req_ready;
        luma_step    = accept && (state_q == ST_LUMA);
        chroma_step  = accept && (state_q == ST_CHROMA);
    end

    nv12_plane_walker #(.AW(AW), .CW(DW), .SW(SW)) u_luma (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start_take),
        .load_addr  (base_addr),
        .load_lines (height),
        .stride     (luma_stride_q),
        .step       (luma_step),
        .line_addr  (luma_addr),
        .last_line  (luma_last)
    );

    nv12_plane_walker #(.AW(AW), .CW(DW), .SW(SW)) u_chroma (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (start_take),
        .load_addr  (chroma_base),
        .load_lines (chroma_lines),
        .stride     (chroma_stride_q),
        .step       (chroma_step),
        .line_addr  (chroma_addr),
        .last_line  (chroma_last)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_take) state_d = ST_LUMA;
            ST_LUMA:   if (luma_step && luma_last) state_d = ST_CHROMA;
            ST_CHROMA: if (chroma_step && chroma_last) state_d = ST_FIN;
            ST_FIN:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state and captured geometry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q         <= ST_IDLE;
            len_q           <= '0;
            height_q        <= '0;
            base_q          <= '0;
            luma_stride_q   <= '0;
            chroma_stride_q <= '0;
            cfg_err_q       <= 1'b0;
        end else begin
            state_q <= state_d;
            if (idle && start) begin
                cfg_err_q <= cfg_bad;
            end
            if (start_take) begin
                len_q           <= width;
                height_q        <= height;
                base_q          <= base_addr;
                luma_stride_q   <= luma_stride;
                chroma_stride_q <= chroma_stride;
            end
        end
    end

    // outputs
    always_comb begin
        req_valid    = 1'b0;
        req_chroma   = PLANE_LUMA;
        req_addr     = '0;
        done         = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_LUMA: begin
                req_valid = 1'b1;
                req_addr  = luma_addr;
            end
            ST_CHROMA: begin
                req_valid  = 1'b1;
                req_chroma = PLANE_CHROMA;
                req_addr   = chroma_addr;
            end
            ST_FIN: begin
                done = 1'b1;
            end
            default: begin
            end
        endcase
        req_len      = len_q;
        busy         = !idle;
        config_error = cfg_err_q;
    end

    // R2: first request appears at the captured base, in the luma plane
    a_r2_first_request: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && start && !cfg_bad) |=>
            (req_valid && !req_chroma && req_addr == $past(base_addr)));

    // R3: an accepted luma line that is not the last moves by the luma stride
    a_r3_luma_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LUMA && accept && !luma_last) |=>
            (!req_chroma && req_addr == $past(req_addr) + AW'(luma_stride_q)));

    // R4: chroma plane begins W*H bytes past the base
    a_r4_chroma_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LUMA && accept && luma_last) |=>
            (req_valid && req_chroma &&
             req_addr == base_q + AW'(PW'(len_q) * PW'(height_q))));

    // R5: a stalled request holds steady
    a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
            (req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_chroma)));

    // R6: done follows the final chroma acceptance and lasts one cycle
    a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHROMA && accept && chroma_last) |=> (done && !req_valid));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R7: a refused geometry never coexists with an active frame
    a_r7_error_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |-> (!req_valid && !busy));

endmodule

// File: tb/tb_nv12_line_seq.sv
module tb_nv12_line_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] base_addr = '0;
    logic [11:0] width = '0;
    logic [11:0] height = '0;
    logic [15:0] luma_stride = '0;
    logic [15:0] chroma_stride = '0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr;
    logic [11:0] req_len;
    logic        req_chroma;
    logic        busy;
    logic        done;
    logic        config_error;

    int unsigned vectors = 0;
    int unsigned miscompares = 0;
    int unsigned cycles = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    nv12_line_seq dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .base_addr     (base_addr),
        .width         (width),
        .height        (height),
        .luma_stride   (luma_stride),
        .chroma_stride (chroma_stride),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_len       (req_len),
        .req_chroma    (req_chroma),
        .busy          (busy),
        .done          (done),
        .config_error  (config_error)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [31:0] b, input int w, input int h,
                                             input int ls, input int cs, input int idx);
        if (idx < h) return b + 32'(idx) * 32'(ls);
        return b + 32'(w) * 32'(h) + 32'(idx - h) * 32'(cs);
    endfunction

    task automatic run_frame(input logic [31:0] b, input int w, input int h, input int ls,
                             input int cs, input int rdy_pct, input bit noise);
        int  idx;
        int  total;
        bit  rdy;
        bit  stalled;
        string lbl;
        logic [31:0] ea;
        @(negedge clk);
        base_addr = b; width = 12'(w); height = 12'(h);
        luma_stride = 16'(ls); chroma_stride = 16'(cs); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(config_error === 1'b0, "R7 cleared by valid start", 64'(config_error), 64'd0);
        total = h + h / 2;
        idx = 0;
        stalled = 1'b0;
        while (idx < total) begin
            ea = exp_addr(b, w, h, ls, cs, idx);
            if (stalled) lbl = "R5";
            else if (idx == 0) lbl = "R2";
            else if (idx < h) lbl = "R3";
            else lbl = "R4";
            if (noise) lbl = {lbl, "/R8/R9"};
            chk(req_valid === 1'b1, lbl, 64'(req_valid), 64'd1);
            chk(req_addr === ea, lbl, 64'(req_addr), 64'(ea));
            chk(req_len === 12'(w), lbl, 64'(req_len), 64'(w));
            chk(req_chroma === (idx >= h), lbl, 64'(req_chroma), 64'(idx >= h));
            chk(busy === 1'b1, lbl, 64'(busy), 64'd1);
            rdy = ($urandom % 100) < rdy_pct;
            req_ready = rdy;
            if (noise) begin
                base_addr = $urandom;
                width = 12'($urandom);
                height = 12'($urandom);
                luma_stride = 16'($urandom);
                chroma_stride = 16'($urandom);
                start = ($urandom % 6) == 0;
            end
            @(negedge clk);
            if (rdy) idx++;
            stalled = !rdy;
        end
        req_ready = 1'b0;
        start = 1'b0;
        chk(done === 1'b1, "R6 done pulse", 64'(done), 64'd1);
        chk(req_valid === 1'b0, "R6 no request in done cycle", 64'(req_valid), 64'd0);
        @(negedge clk);
        chk(done === 1'b0, "R6 done one cycle", 64'(done), 64'd0);
        chk(busy === 1'b0, "R6 idle after done", 64'(busy), 64'd0);
    endtask

    task automatic err_case(input int w, input int h, input int ls, input int cs,
                            input string why);
        @(negedge clk);
        base_addr = 32'h1000; width = 12'(w); height = 12'(h);
        luma_stride = 16'(ls); chroma_stride = 16'(cs); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(config_error === 1'b1, {"R7 flag ", why}, 64'(config_error), 64'd1);
        chk(req_valid === 1'b0, {"R7 no request ", why}, 64'(req_valid), 64'd0);
        chk(busy === 1'b0, {"R7 not busy ", why}, 64'(busy), 64'd0);
        repeat (3) @(negedge clk);
        chk(req_valid === 1'b0, {"R7 still quiet ", why}, 64'(req_valid), 64'd0);
        chk(config_error === 1'b1, {"R7 flag held ", why}, 64'(config_error), 64'd1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            miscompares++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(req_valid === 1'b0, "R1 valid", 64'(req_valid), 64'd0);
        chk(done === 1'b0, "R1 done", 64'(done), 64'd0);
        chk(busy === 1'b0, "R1 busy", 64'(busy), 64'd0);
        chk(config_error === 1'b0, "R1 error", 64'(config_error), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // smallest legal frame, strides equal to the width
        run_frame(32'h0000_4000, 2, 2, 2, 2, 100, 1'b0);
        // tightly packed frame, full speed
        run_frame(32'h8000_0000, 8, 4, 8, 8, 100, 1'b0);
        // padded strides with heavy backpressure
        run_frame(32'h0010_0000, 16, 6, 64, 32, 30, 1'b0);

        err_case(7, 4, 8, 8, "odd width");
        err_case(8, 5, 8, 8, "odd height");
        err_case(0, 4, 8, 8, "zero width");
        err_case(8, 0, 8, 8, "zero height");
        err_case(8, 4, 6, 8, "short luma stride");
        err_case(8, 4, 8, 7, "short chroma stride");

        // address wrap near the top of the space
        run_frame(32'hFFFF_FF00, 32, 4, 40, 48, 70, 1'b0);

        for (int f = 0; f < 24; f++) begin
            int w;
            int h;
            w = 2 * (1 + int'($urandom % 32));
            h = 2 * (1 + int'($urandom % 8));
            run_frame($urandom, w, h, w + int'($urandom % 9), w + int'($urandom % 9),
                      40 + int'($urandom % 61), (f % 2) == 1);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule